// File: doc/BRIEF.md
# E1 Timeslot Idle Code Inserter

This block sits in the transmit path of an E1 framer. It overwrites chosen 8-bit timeslots of the outgoing 2.048 Mb/s serial stream with one programmable 8-bit idle pattern. The pattern is sent most significant bit first. All other timeslots pass through untouched. The datapath receives one bit per bit-clock enable, together with a frame-sync strobe. It tracks the timeslot and the bit position inside the timeslot. The output bit is registered.

A small byte-wide register port holds the idle code and a 32-bit per-channel enable mask, split over four bytes. The enable bit and the code are captured at the first bit of every timeslot. A register write can therefore land at any moment without producing a mixed byte on the wire.

Top module: `e1_idle_inserter`

## Requirements
- R1: For a timeslot whose enable bit is 0, `dout` equals the `din` bit that was presented with `bit_en` high. It changes on the same rising edge where that `bit_en` is sampled, so the latency is one bit.
- R2: For a timeslot whose enable bit is 1, the bit at position k of the timeslot (k = 0 is sent first) is replaced by idle code bit 7-k, so the code goes out MSB first.
- R3: A cycle with `bit_en` and `fsync` both high carries bit 0 of timeslot 0 (channel 1). This holds at any point in the frame. Without `fsync`, the position advances by one per `bit_en` and wraps from timeslot 31 bit 7 to timeslot 0 bit 0.
- R4: The enable bytes are at addresses 0x24, 0x25, 0x26 and 0x27. Bit j of the byte at 0x24+g enables channel 8g+j+1, which is timeslot 8g+j.
- R5: The idle code is held in the byte at address 0x23.
- R6: The enable bit and the idle code take effect only at bit 0 of a timeslot. A write made later in that timeslot changes nothing in it and applies from the next timeslot on.
- R7: `reg_rdata` shows the stored byte one clock after a cycle with `reg_rd` high. An unmapped address reads as 0x00.
- R8: A write to an unmapped address changes neither the stored bytes nor the output stream.
- R9: After reset the mask is all zero, the idle code is 0xFF, `dout` is 0 and the position is timeslot 0 bit 0.
- R10: `dout` holds its value in every cycle where `bit_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| fsync | input | 1 | Marks the first bit of timeslot 0, valid with `bit_en` |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, registered |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the clock after `reg_rd` |

## Verification
Each serial result is due on the rising edge that samples its `bit_en`. The bench drives a bit at the falling edge, waits for the next rising edge and samples `dout` 1 ns later. It then lowers `bit_en`, so exactly one bit is consumed per call. Read data is due one edge after `reg_rd` and is sampled the same way. The bench model captures the enable bit and code at bit 0 of each timeslot, as R6 requires, so mid-timeslot writes are predicted at the timeslot boundary. Cycles with `bit_en` low are checked for an unchanged `dout` across several idle clocks.

// File: rtl/idle_ins_pkg.sv
package idle_ins_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CODE = 2'd1,
      SEL_MASK = 2'd2
   } reg_sel_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs
   import idle_ins_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned CODE_ADDR = 'h23,
   parameter int unsigned MASK_BASE = 'h24,
   parameter logic [SLOT_BITS-1:0] CODE_RST = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [SLOT_BITS-1:0] wdata,
   input  logic                 wr,
   input  logic                 rd,
   output logic [SLOT_BITS-1:0] rdata,
   output logic [SLOTS-1:0]     mask,
   output logic [SLOT_BITS-1:0] code
);

   localparam int unsigned GROUPS = SLOTS / SLOT_BITS;
   localparam int unsigned GRP_W  = idx_width(GROUPS);
   localparam logic [ADDR_W-1:0] CODE_A = ADDR_W'(CODE_ADDR);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_BASE);
   localparam logic [ADDR_W-1:0] GRP_N  = ADDR_W'(GROUPS);

   if (SLOTS % SLOT_BITS != 0) begin : g_bad_split
      $error("SLOTS must be a multiple of SLOT_BITS");
   end
   if (CODE_ADDR >= MASK_BASE && CODE_ADDR < MASK_BASE + GROUPS) begin : g_bad_map
      $error("code address overlaps the mask window");
   end
   if (MASK_BASE + GROUPS > (1 << ADDR_W)) begin : g_bad_addr
      $error("mask window does not fit the address width");
   end

   reg_sel_e             sel;
   logic [ADDR_W-1:0]    off;
   logic [GRP_W-1:0]     grp;
   logic [SLOT_BITS-1:0] code_q;
   logic [SLOT_BITS-1:0] grp_rd [GROUPS];

   assign off = addr - MASK_A;
   assign grp = off[GRP_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (addr == CODE_A)
         sel = SEL_CODE;
      else if (addr >= MASK_A && off < GRP_N)
         sel = SEL_MASK;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [SLOT_BITS-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr && sel == SEL_MASK && grp == GRP_W'(g))
            q <= wdata;
      end
      assign mask[g*SLOT_BITS +: SLOT_BITS] = q;
      assign grp_rd[g] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         code_q <= CODE_RST;
      else if (wr && sel == SEL_CODE)
         code_q <= wdata;
   end
   assign code = code_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd) begin
         unique case (sel)
            SEL_CODE: rdata <= code_q;
            SEL_MASK: rdata <= grp_rd[grp];
            default:  rdata <= '0;
         endcase
      end
   end

   assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel == SEL_NONE |=> $stable(mask) && $stable(code));

   assert_code_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel == SEL_CODE |=> code == $past(wdata));

   assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd && sel == SEL_NONE |=> rdata == '0);

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
   import idle_ins_pkg::*;
#(
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SLOT_BITS = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bit_en,
   input  logic                                fsync,
   output logic [idx_width(SLOTS)-1:0]         cur_slot,
   output logic [idx_width(SLOT_BITS)-1:0]     cur_bit,
   output logic                                first
);

   localparam int unsigned SLOT_W = idx_width(SLOTS);
   localparam int unsigned BIT_W  = idx_width(SLOT_BITS);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

   if (SLOTS < 2 || SLOT_BITS < 2) begin : g_bad_size
      $error("frame needs at least two timeslots of at least two bits");
   end

   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;

   assign cur_slot = fsync ? '0 : slot_q;
   assign cur_bit  = fsync ? '0 : bit_q;
   assign first    = (cur_bit == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else if (bit_en) begin
         if (cur_bit == LAST_BIT) begin
            bit_q  <= '0;
            slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
         end else begin
            bit_q  <= cur_bit + 1'b1;
            slot_q <= cur_slot;
         end
      end
   end

   assert_fsync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && fsync |=> slot_q == '0 && bit_q == BIT_W'(1));

   assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !fsync && slot_q == LAST_SLOT && bit_q == LAST_BIT
      |=> slot_q == '0 && bit_q == '0);

   assert_pos_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(slot_q) && $stable(bit_q));

endmodule

// File: rtl/idle_sub_path.sv
module idle_sub_path
   import idle_ins_pkg::*;
#(
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SLOT_BITS = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bit_en,
   input  logic                             din,
   input  logic [idx_width(SLOTS)-1:0]      cur_slot,
   input  logic [idx_width(SLOT_BITS)-1:0]  cur_bit,
   input  logic                             first,
   input  logic [SLOTS-1:0]                 mask,
   input  logic [SLOT_BITS-1:0]             code,
   output logic                             dout
);

   localparam int unsigned BIT_W = idx_width(SLOT_BITS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

   logic                 ins_q;
   logic [SLOT_BITS-1:0] code_q;
   logic                 ins_now;
   logic [SLOT_BITS-1:0] code_now;
   logic [BIT_W-1:0]     sel_idx;

   assign ins_now  = first ? mask[cur_slot] : ins_q;
   assign code_now = first ? code : code_q;
   assign sel_idx  = LAST_BIT - cur_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_q  <= 1'b0;
         code_q <= '0;
      end else if (bit_en && first) begin
         ins_q  <= mask[cur_slot];
         code_q <= code;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         dout <= 1'b0;
      else if (bit_en)
         dout <= ins_now ? code_now[sel_idx] : din;
   end

   assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !ins_now |=> dout == $past(din));

   assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(dout));

   assert_slot_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !first |=> $stable(ins_q) && $stable(code_q));

endmodule

// File: rtl/e1_idle_inserter.sv
module e1_idle_inserter
   import idle_ins_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned CODE_ADDR = 'h23,
   parameter int unsigned MASK_BASE = 'h24,
   parameter logic [SLOT_BITS-1:0] CODE_RST = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 fsync,
   input  logic                 din,
   output logic                 dout,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [SLOT_BITS-1:0] reg_wdata,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   output logic [SLOT_BITS-1:0] reg_rdata
);

   localparam int unsigned SLOT_W = idx_width(SLOTS);
   localparam int unsigned BIT_W  = idx_width(SLOT_BITS);

   logic [SLOTS-1:0]     mask;
   logic [SLOT_BITS-1:0] code;
   logic [SLOT_W-1:0]    cur_slot;
   logic [BIT_W-1:0]     cur_bit;
   logic                 first;

   idle_cfg_regs #(
      .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS),
      .CODE_ADDR(CODE_ADDR), .MASK_BASE(MASK_BASE), .CODE_RST(CODE_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata), .mask(mask), .code(code)
   );

   slot_tracker #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_track (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
      .cur_slot(cur_slot), .cur_bit(cur_bit), .first(first)
   );

   idle_sub_path #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_sub (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
      .cur_slot(cur_slot), .cur_bit(cur_bit), .first(first),
      .mask(mask), .code(code), .dout(dout)
   );

endmodule

// File: tb/sim_e1_idle_inserter.sv
`timescale 1ns/1ps
module sim_e1_idle_inserter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       fsync = 1'b0;
   logic       din = 1'b0;
   logic       dout;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 0;

   logic [31:0] m_mask = '0;
   logic [7:0]  m_code = 8'hFF;
   int          m_pos = 0;
   logic        m_ins = 1'b0;
   logic [7:0]  m_lcode = '0;

   always #2.5 clk = ~clk;

   e1_idle_inserter u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .din(din),
      .dout(dout), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   task automatic check(input bit ok, input string req, input int got, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic pat(input int p, input int seed);
      int v = p * 13 + seed * 7 + (p >> 3);
      return v[2] ^ v[0];
   endfunction

   task automatic send_bit(input logic fs, input logic d, input string req);
      int cur;
      int s;
      int b;
      logic exp;
      @(negedge clk);
      bit_en = 1'b1; fsync = fs; din = d;
      cur = fs ? 0 : m_pos;
      s = cur / 8;
      b = cur % 8;
      if (b == 0) begin
         m_ins = m_mask[s];
         m_lcode = m_code;
      end
      exp = m_ins ? m_lcode[7-b] : d;
      @(posedge clk); #1;
      bit_en = 1'b0; fsync = 1'b0;
      check(dout === exp, req, int'(dout), int'(exp));
      m_pos = (cur + 1) % 256;
   endtask

   task automatic send_frame(input int seed, input string req);
      for (int i = 0; i < 256; i++) send_bit(i == 0, pat(i, seed), req);
   endtask

   task automatic gap(input int n);
      logic held;
      held = dout;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         check(dout === held, "R10", int'(dout), int'(held));
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      if (a == 8'h23) m_code = d;
      else if (a >= 8'h24 && a <= 8'h27) m_mask[(a - 8'h24) * 8 +: 8] = d;
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(posedge clk); #1;
      reg_rd = 1'b0;
      check(reg_rdata === exp, req, int'(reg_rdata), int'(exp));
   endtask

   task automatic set_mask(input logic [31:0] m);
      for (int g = 0; g < 4; g++) wr_reg(8'h24 + 8'(g), m[g*8 +: 8]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: reset state
      check(dout === 1'b0, "R9", int'(dout), 0);
      rd_check(8'h23, 8'hFF, "R9");
      for (int g = 0; g < 4; g++) rd_check(8'h24 + 8'(g), 8'h00, "R9");
      rd_check(8'h22, 8'h00, "R7");
      rd_check(8'h28, 8'h00, "R7");
      // R9/R3: counting starts at slot 0 after reset, no fsync
      for (int i = 0; i < 16; i++) send_bit(1'b0, pat(i, 1), "R9");
      // R1: all channels pass
      send_frame(2, "R1");
      gap(4);
      // R2/R5: all channels replaced
      wr_reg(8'h23, 8'hA5);
      rd_check(8'h23, 8'hA5, "R5");
      set_mask('1);
      send_frame(3, "R2");
      // R4: walking single channel
      wr_reg(8'h23, 8'h96);
      for (int ch = 0; ch < 32; ch++) begin
         set_mask(32'h1 << ch);
         rd_check(8'h24 + 8'(ch / 8), 8'h1 << (ch % 8), "R4");
         send_frame(ch + 10, "R4");
      end
      // R2/R4: mixed patterns and codes
      wr_reg(8'h23, 8'h00); set_mask(32'h55AA0FF0); send_frame(50, "R2");
      wr_reg(8'h23, 8'hFF); set_mask(32'hF00F33CC); send_frame(51, "R2");
      wr_reg(8'h23, 8'h3C); set_mask(32'h80000001); send_frame(52, "R4");
      // R8: unmapped writes
      wr_reg(8'h22, 8'h00);
      wr_reg(8'h28, 8'hFF);
      wr_reg(8'hA4, 8'hFF);
      rd_check(8'h23, 8'h3C, "R8");
      rd_check(8'h24, 8'h01, "R8");
      rd_check(8'h27, 8'h80, "R8");
      send_frame(53, "R8");
      // R6: writes in the middle of timeslot 5
      wr_reg(8'h23, 8'h81);
      set_mask('1);
      for (int i = 0; i < 43; i++) send_bit(i == 0, pat(i, 60), "R6");
      wr_reg(8'h23, 8'h7E);
      wr_reg(8'h24, 8'hDF);
      for (int i = 43; i < 64; i++) send_bit(1'b0, pat(i, 60), "R6");
      set_mask(32'h0000_0020);
      for (int i = 64; i < 256; i++) send_bit(1'b0, pat(i, 61), "R6");
      // R3: wrap without fsync, then fsync mid-frame
      wr_reg(8'h23, 8'hC3);
      set_mask(32'h8000_0003);
      for (int i = 0; i < 300; i++) send_bit(1'b0, pat(i, 70), "R3");
      for (int i = 0; i < 300; i++) send_bit(i == 0 || i == 101, pat(i, 71), "R3");
      // R10: idle clocks between bits
      for (int i = 0; i < 24; i++) begin
         send_bit(1'b0, pat(i, 80), "R10");
         gap(i % 3 + 1);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule